// File: doc/BRIEF.md
# Product lifecycle state controller

This block turns the non-volatile lifecycle fields of a device into one of four product states: Open, Provisioning, Closed or Locked. It also decides where the device boots, whether boot from SRAM is allowed, and whether debug authentication may be attempted. The fields are a one-bit open/closed flag, an 8-bit provisioning-done byte and an 8-bit debug-authentication byte. Fixed magic byte values in those fields separate the finalized states from Provisioning. The block samples the decoded state once, on the first clock after reset is released, and holds it until the next reset. Changes to the non-volatile fields therefore take effect only across a reset.

Software or a provisioning agent asks for a state change with a one-cycle request. A legal request is latched in a pending-state register, which the non-volatile writer outside this block commits. The current state does not change until the next reset. A request that is illegal, or that arrives while a change is already pending, is dropped and sets a sticky error flag. In Closed, a successful debug authentication (reported by an outside engine as a pulse) starts a regression back to Open. The regression is either full or debug-constrained, and its one-cycle request tells the secret store to erase.

Top module: `lc_ctrl`

## Requirements
- R1: When `nv_closed` is 0, the state is Open (code 2'b00), whatever the two bytes hold.
- R2: When `nv_closed` is 1, `prov_byte` is 0xB4 and `dbg_byte` is 0x51 or 0x8A, the state is Closed (code 2'b10).
- R3: When `nv_closed` is 1, `prov_byte` is 0xB4 and `dbg_byte` is 0xB4, the state is Locked (code 2'b11).
- R4: When `nv_closed` is 1 and the bytes match neither R2 nor R3, the state is Provisioning (code 2'b01).
- R5: While `rst_n` is low, `state` reads Provisioning. The decoded state appears after the first rising edge following reset release. It then holds, even if the non-volatile inputs change, until the next reset.
- R6: `sram_boot_ok` is 0 in Provisioning and 1 in every other state.
- R7: `boot_vendor` is 1 only when `rot_sel` is 1 and the state is Closed or Locked. Otherwise it is 0, which selects the OEM root of trust in user flash.
- R8: A `req_valid` pulse asking Open to Provisioning, Provisioning to Closed, or Provisioning to Locked sets `pend_valid` and `pend_state` at the next edge. `state` is left unchanged. Once `pend_valid` is set, it and `pend_state` hold until reset.
- R9: Any other request, including every request in Locked, leaves `pend_valid` as it was and sets `err`. `err` stays 1 until reset.
- R10: `dbg_permit` is 1 only in Closed. In Closed with nothing pending, an `auth_ok` pulse has three effects at the next edge: a one-cycle `regress_req`, `regress_full` equal to `auth_full`, and a pending state of Open.
- R11: An `auth_ok` pulse outside Closed, or while a change is pending, is ignored and sets `err`. A `req_valid` in the same cycle as `auth_ok` is ignored and sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nv_closed | input | 1 | Non-volatile state flag, 1 = closed |
| prov_byte | input | 8 | Provisioning-done byte |
| dbg_byte | input | 8 | Debug-authentication configuration byte |
| rot_sel | input | 1 | Selects the vendor root of trust |
| req_valid | input | 1 | One-cycle transition request |
| req_state | input | 2 | Requested target state code |
| auth_ok | input | 1 | One-cycle debug-authentication success |
| auth_full | input | 1 | 1 = full regression, 0 = constrained-debug regression |
| state | output | 2 | Current product state code |
| boot_vendor | output | 1 | 1 = boot vendor root of trust, 0 = OEM root of trust |
| sram_boot_ok | output | 1 | Boot from SRAM permitted |
| dbg_permit | output | 1 | Debug authentication may be attempted |
| pend_valid | output | 1 | A state change is pending |
| pend_state | output | 2 | Pending target state code |
| regress_req | output | 1 | One-cycle regression and secret-erase request |
| regress_full | output | 1 | Kind of the last regression |
| err | output | 1 | Sticky rejected-request flag |

## Verification
The hardest situations to reach are the ones where a regression collides with other events. These are a debug-authentication success in the same cycle as a transition request, and a second authentication once a regression is already pending. Both need the device to be brought up in Closed first. The bench does this by holding the magic byte values through a reset and then issuing the colliding pulses on a single cycle. The hold-after-reset rule is reached by changing the non-volatile inputs well after reset and checking that the state does not move.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    LC_OPEN   = 2'b00,
    LC_PROV   = 2'b01,
    LC_CLOSED = 2'b10,
    LC_LOCKED = 2'b11
  } lc_state_e;

  // Forward moves a plain request may ask for; everything else is refused.
  function automatic logic lc_move_ok(lc_state_e from_s, lc_state_e to_s);
    logic ok;
    ok = 1'b0;
    unique case (from_s)
      LC_OPEN: ok = (to_s == LC_PROV);
      LC_PROV: ok = (to_s == LC_CLOSED) || (to_s == LC_LOCKED);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic lc_is_final(lc_state_e s);
    return (s == LC_CLOSED) || (s == LC_LOCKED);
  endfunction
endpackage

// File: rtl/lc_decode.sv
module lc_decode
  import lc_pkg::*;
#(
  parameter int          FIELD_W    = 8,
  parameter logic [FIELD_W-1:0] PROV_MAGIC = 8'hB4,
  parameter logic [FIELD_W-1:0] LOCK_MAGIC = 8'hB4,
  parameter logic [FIELD_W-1:0] DBG_MAGIC_A = 8'h51,
  parameter logic [FIELD_W-1:0] DBG_MAGIC_B = 8'h8A
) (
  input  logic               nv_closed,
  input  logic [FIELD_W-1:0] prov_byte,
  input  logic [FIELD_W-1:0] dbg_byte,
  output lc_state_e          dec_state
);
  logic prov_done;
  logic dbg_open;
  logic dbg_lock;

  assign prov_done = (prov_byte == PROV_MAGIC);
  assign dbg_open  = (dbg_byte == DBG_MAGIC_A) || (dbg_byte == DBG_MAGIC_B);
  assign dbg_lock  = (dbg_byte == LOCK_MAGIC);

  always_comb begin
    if (!nv_closed)               dec_state = LC_OPEN;
    else if (prov_done && dbg_lock) dec_state = LC_LOCKED;
    else if (prov_done && dbg_open) dec_state = LC_CLOSED;
    else                          dec_state = LC_PROV;
  end
endmodule

// File: rtl/lc_transition.sv
module lc_transition
  import lc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lc_state_e dec_state,
  input  logic      req_valid,
  input  lc_state_e req_state,
  input  logic      auth_ok,
  input  logic      auth_full,
  output lc_state_e cur_state,
  output logic      pend_valid,
  output lc_state_e pend_state,
  output logic      regress_req,
  output logic      regress_full,
  output logic      err
);
  logic sampled;
  logic auth_accept;
  logic req_accept;
  logic reject_ev;

  assign auth_accept = sampled && auth_ok && (cur_state == LC_CLOSED) && !pend_valid;
  assign req_accept  = sampled && req_valid && !auth_ok && !pend_valid &&
                       lc_move_ok(cur_state, req_state);
  assign reject_ev   = sampled && ((auth_ok && !auth_accept) ||
                                   (req_valid && !req_accept));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled      <= 1'b0;
      cur_state    <= LC_PROV;
      pend_valid   <= 1'b0;
      pend_state   <= LC_OPEN;
      regress_req  <= 1'b0;
      regress_full <= 1'b0;
      err          <= 1'b0;
    end else begin
      regress_req <= 1'b0;
      if (!sampled) begin
        cur_state <= dec_state;
        sampled   <= 1'b1;
      end else begin
        if (auth_accept) begin
          pend_valid   <= 1'b1;
          pend_state   <= LC_OPEN;
          regress_req  <= 1'b1;
          regress_full <= auth_full;
        end else if (req_accept) begin
          pend_valid <= 1'b1;
          pend_state <= req_state;
        end
        if (reject_ev) err <= 1'b1;
      end
    end
  end

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sampled |=> $stable(cur_state)); // R5
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |=> (pend_valid && $stable(pend_state))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_LOCKED_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == LC_LOCKED) |-> !pend_valid); // R9
  AST_REGRESS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    regress_req |-> (cur_state == LC_CLOSED && pend_valid && pend_state == LC_OPEN)); // R10
  AST_REGRESS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    regress_req |=> !regress_req); // R10
endmodule

// File: rtl/lc_boot_policy.sv
module lc_boot_policy
  import lc_pkg::*;
(
  input  lc_state_e cur_state,
  input  logic      rot_sel,
  output logic      boot_vendor,
  output logic      sram_boot_ok,
  output logic      dbg_permit
);
  assign boot_vendor  = rot_sel && lc_is_final(cur_state);
  assign sram_boot_ok = (cur_state != LC_PROV);
  assign dbg_permit   = (cur_state == LC_CLOSED);
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter logic [FIELD_W-1:0] PROV_MAGIC  = 8'hB4,
  parameter logic [FIELD_W-1:0] LOCK_MAGIC  = 8'hB4,
  parameter logic [FIELD_W-1:0] DBG_MAGIC_A = 8'h51,
  parameter logic [FIELD_W-1:0] DBG_MAGIC_B = 8'h8A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nv_closed,
  input  logic [FIELD_W-1:0] prov_byte,
  input  logic [FIELD_W-1:0] dbg_byte,
  input  logic               rot_sel,
  input  logic               req_valid,
  input  logic [1:0]         req_state,
  input  logic               auth_ok,
  input  logic               auth_full,
  output logic [1:0]         state,
  output logic               boot_vendor,
  output logic               sram_boot_ok,
  output logic               dbg_permit,
  output logic               pend_valid,
  output logic [1:0]         pend_state,
  output logic               regress_req,
  output logic               regress_full,
  output logic               err
);
  lc_state_e dec_state;
  lc_state_e cur_state;
  lc_state_e pend_s;
  lc_state_e req_s;

  assign req_s = lc_state_e'(req_state);

  lc_decode #(
    .FIELD_W(FIELD_W), .PROV_MAGIC(PROV_MAGIC), .LOCK_MAGIC(LOCK_MAGIC),
    .DBG_MAGIC_A(DBG_MAGIC_A), .DBG_MAGIC_B(DBG_MAGIC_B)
  ) u_decode (
    .nv_closed(nv_closed), .prov_byte(prov_byte), .dbg_byte(dbg_byte),
    .dec_state(dec_state)
  );

  lc_transition u_trans (
    .clk(clk), .rst_n(rst_n), .dec_state(dec_state),
    .req_valid(req_valid), .req_state(req_s),
    .auth_ok(auth_ok), .auth_full(auth_full),
    .cur_state(cur_state), .pend_valid(pend_valid), .pend_state(pend_s),
    .regress_req(regress_req), .regress_full(regress_full), .err(err)
  );

  lc_boot_policy u_policy (
    .cur_state(cur_state), .rot_sel(rot_sel),
    .boot_vendor(boot_vendor), .sram_boot_ok(sram_boot_ok),
    .dbg_permit(dbg_permit)
  );

  assign state      = cur_state;
  assign pend_state = pend_s;

  AST_VENDOR_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    boot_vendor |-> (state == 2'b10 || state == 2'b11)); // R7
  AST_PROV_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b01) |-> !sram_boot_ok); // R6
  AST_REGRESS_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    regress_req |-> dbg_permit); // R10
endmodule

// File: tb/lc_ctrl_bench.sv
module lc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv_closed = 1'b0;
  logic [7:0] prov_byte = 8'h00;
  logic [7:0] dbg_byte = 8'h00;
  logic       rot_sel = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_state = 2'b00;
  logic       auth_ok = 1'b0;
  logic       auth_full = 1'b0;
  logic [1:0] state;
  logic       boot_vendor, sram_boot_ok, dbg_permit;
  logic       pend_valid, regress_req, regress_full, err;
  logic [1:0] pend_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lc_ctrl u_lc_ctrl (
    .clk(clk), .rst_n(rst_n), .nv_closed(nv_closed), .prov_byte(prov_byte),
    .dbg_byte(dbg_byte), .rot_sel(rot_sel), .req_valid(req_valid),
    .req_state(req_state), .auth_ok(auth_ok), .auth_full(auth_full),
    .state(state), .boot_vendor(boot_vendor), .sram_boot_ok(sram_boot_ok),
    .dbg_permit(dbg_permit), .pend_valid(pend_valid), .pend_state(pend_state),
    .regress_req(regress_req), .regress_full(regress_full), .err(err)
  );

  // {nv_closed, prov, dbg, expected state}
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 8'hB4, 8'hB4, 2'b00},  // R1
    {1'b0, 8'h12, 8'h51, 2'b00},  // R1
    {1'b1, 8'hB4, 8'h51, 2'b10},  // R2
    {1'b1, 8'hB4, 8'h8A, 2'b10},  // R2
    {1'b1, 8'hB4, 8'hB4, 2'b11},  // R3
    {1'b1, 8'hB5, 8'hB4, 2'b01},  // R4
    {1'b1, 8'hB4, 8'h00, 2'b01},  // R4
    {1'b1, 8'h00, 8'h51, 2'b01},  // R4
    {1'b1, 8'hB4, 8'h52, 2'b01}   // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic boot(input logic c, input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    rst_n = 1'b0; nv_closed = c; prov_byte = p; dbg_byte = d;
    req_valid = 1'b0; auth_ok = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input logic rv, input logic [1:0] rs, input logic ao, input logic af);
    req_valid = rv; req_state = rs; auth_ok = ao; auth_full = af;
    @(negedge clk);
    req_valid = 1'b0; auth_ok = 1'b0;
  endtask

  initial begin
    // Reset-time value
    rst_n = 1'b0; nv_closed = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 state during reset", state, 2'b01);
    chk("R8 pend during reset", pend_valid, 0);
    chk("R9 err during reset", err, 0);

    // Decode table
    for (int i = 0; i < NV; i++) begin
      boot(VEC[i][18], VEC[i][17:10], VEC[i][9:2]);
      chk($sformatf("R1-4 decode vec %0d", i), state, VEC[i][1:0]);
      chk($sformatf("R6 sram vec %0d", i), sram_boot_ok, VEC[i][1:0] != 2'b01);
      chk($sformatf("R10 permit vec %0d", i), dbg_permit, VEC[i][1:0] == 2'b10);
    end

    // R5: inputs change after sampling, state holds
    boot(1'b0, 8'h00, 8'h00);
    nv_closed = 1'b1; prov_byte = 8'hB4; dbg_byte = 8'hB4;
    repeat (3) @(negedge clk);
    chk("R5 hold after nv change", state, 2'b00);

    // R8: Open -> Provisioning, then second request refused
    boot(1'b0, 8'h00, 8'h00);
    pulse(1'b1, 2'b01, 1'b0, 1'b0);
    chk("R8 pend_valid", pend_valid, 1);
    chk("R8 pend_state", pend_state, 2'b01);
    chk("R8 state unchanged", state, 2'b00);
    chk("R8 no err", err, 0);
    pulse(1'b1, 2'b01, 1'b0, 1'b0);
    chk("R8 second request err", err, 1);
    chk("R8 pend kept", pend_state, 2'b01);

    // R9: illegal Open -> Closed
    boot(1'b0, 8'h00, 8'h00);
    pulse(1'b1, 2'b10, 1'b0, 1'b0);
    chk("R9 illegal no pend", pend_valid, 0);
    chk("R9 err set", err, 1);
    repeat (3) @(negedge clk);
    chk("R9 err sticky", err, 1);

    // R7/R8: Provisioning, vendor select ignored, Prov -> Locked
    rot_sel = 1'b1;
    boot(1'b1, 8'h00, 8'h00);
    chk("R7 prov boots oem", boot_vendor, 0);
    chk("R6 prov sram denied", sram_boot_ok, 0);
    pulse(1'b1, 2'b11, 1'b0, 1'b0);
    chk("R8 prov to locked", pend_state, 2'b11);
    chk("R8 prov to locked valid", pend_valid, 1);

    // R10: Closed, constrained regression
    boot(1'b1, 8'hB4, 8'h8A);
    chk("R7 closed vendor boot", boot_vendor, 1);
    rot_sel = 1'b0;
    #0 @(negedge clk);
    chk("R7 closed oem when unselected", boot_vendor, 0);
    rot_sel = 1'b1;
    pulse(1'b0, 2'b00, 1'b1, 1'b0);
    chk("R10 regress pulse", regress_req, 1);
    chk("R10 regress kind", regress_full, 0);
    chk("R10 pend open", pend_state, 2'b00);
    chk("R10 pend valid", pend_valid, 1);
    chk("R10 no err", err, 0);
    @(negedge clk);
    chk("R10 pulse one cycle", regress_req, 0);
    pulse(1'b0, 2'b00, 1'b1, 1'b1);
    chk("R11 auth while pending err", err, 1);
    chk("R11 no second regress", regress_req, 0);

    // R11: Closed, auth together with request
    boot(1'b1, 8'hB4, 8'h51);
    pulse(1'b1, 2'b11, 1'b1, 1'b1);
    chk("R11 collide regress", regress_req, 1);
    chk("R11 collide full", regress_full, 1);
    chk("R11 collide pend open", pend_state, 2'b00);
    chk("R11 collide err", err, 1);

    // R9/R11: Locked refuses everything
    boot(1'b1, 8'hB4, 8'hB4);
    chk("R7 locked vendor boot", boot_vendor, 1);
    chk("R10 locked no permit", dbg_permit, 0);
    pulse(1'b1, 2'b00, 1'b0, 1'b0);
    chk("R9 locked no pend", pend_valid, 0);
    chk("R9 locked err", err, 1);
    pulse(1'b0, 2'b00, 1'b1, 1'b1);
    chk("R11 locked no regress", regress_req, 0);
    chk("R11 locked pend still clear", pend_valid, 0);

    // R11: auth in Open
    boot(1'b0, 8'h00, 8'h00);
    pulse(1'b0, 2'b00, 1'b1, 1'b0);
    chk("R11 open auth err", err, 1);
    chk("R11 open auth no regress", regress_req, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule